// File: doc/BRIEF.md
# Programmable Reference-Clock Divider with Control Register

This block derives a slower reference clock for a serial port from the system clock. Software programs the ratio by writing one byte to a fixed I/O port on a simple host bus. Each access is a one-cycle write or read strobe, with an 8-bit port address and 8-bit data. The same byte also carries an enable flag, which is passed to a separate watchdog timer.

The six low bits of the byte hold the settings:

- Bits 3:0 hold an exponent n.
- Bit 4 selects between a plain binary ratio of 2^n and a ratio of 3·2^n.
- Bit 5 is the watchdog enable.

The ratio is built from two stages. A divide-by-three stage is switched in or bypassed, and a binary counter stage follows it. Both stages together give every ratio from 1 to 98304 that has the form 2^n or 3·2^n.

The block provides two outputs at the divided rate. One is a clock-like square wave and the other is a one-cycle enable strobe. Both outputs are decoded only from registered counter state. A new ratio is applied only when the current output period ends, so no shortened period ever appears on either output.

The host bus has no data stream, so none of its pins use a valid/ready handshake. All pins are plain control and status signals.

Top module: `uclk_div_ctrl`

## Requirements
- R1: After reset the control byte is 0x00. Therefore the ratio is 1, `wdog_en` is 0 and a read of the port returns 0x00.
- R2: A write strobe with `io_addr` equal to 0x6D loads `io_wdata[5:0]` into the control byte. A write to any other address leaves the control byte unchanged.
- R3: `wdog_en` equals bit 5 of the control byte. A read-modify-write that sets bit 5 keeps the divider setting, and the ratio does not change.
- R4: With bit 4 = 0 the ratio N is 2^n, where n is bits 3:0. With bit 4 = 1 the ratio N is 3·2^n. Consecutive `div_tick` pulses are exactly N cycles apart.
- R5: The waveform of `div_clk` depends on N:
  - For N = 1, `div_clk` stays high.
  - For N = 3, `div_clk` is high for the first cycle of each period only.
  - For every other N, `div_clk` is high for the first N/2 cycles of each period and low for the rest.
- R6: `div_tick` is high for exactly the last cycle of each period. For N ≥ 2, `div_clk` is low in that cycle.
- R7: When `io_rd` is high and `io_addr` is 0x6D, `io_rdata` shows {2'b00, control[5:0]} in the same cycle. At all other times `io_rdata` is 0x00. Bits 7:6 always read as 0.
- R8: The active ratio is reloaded from the control byte only at the clock edge that ends a period. A write in the middle of a period does not shorten or extend that period.
- R9: Code 0x0F gives a period of 32768 cycles and code 0x1F gives a period of 98304 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that is divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Host write strobe, one cycle |
| io_rd | input | 1 | Host read strobe |
| io_addr | input | 8 | Host port address |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data; zero unless this port is read |
| wdog_en | output | 1 | Watchdog enable flag (bit 5 of the control byte) |
| div_clk | output | 1 | Divided square wave |
| div_tick | output | 1 | One-cycle strobe at the end of each divided period |

## Verification
The bench builds the block with its default parameters: a 4-bit exponent field, an 8-bit data bus and port address 0x6D. These defaults make every one of the 32 ratio codes reachable, up to the full 98304-cycle period.

A behavioural model tracks the position within the current period and the pending ratio. The bench compares the model with every output on every cycle. Tick-spacing checks measure ratios 1, 2, 3, 6, 8, 12, 32, 32768 and 98304. They include a write that lands in the middle of a period and a write of a new code while a long period is still running.

// File: rtl/uclk_pkg.sv
package uclk_pkg;
  // phase of the divide-by-three stage
  typedef enum logic [1:0] {
    PH0 = 2'd0,
    PH1 = 2'd1,
    PH2 = 2'd2
  } ph3_e;

  // control field positions relative to the exponent width
  function automatic int triple_pos(input int exp_w);
    return exp_w;
  endfunction

  function automatic int wdog_pos(input int exp_w);
    return exp_w + 1;
  endfunction
endpackage

// File: rtl/uclk_ctl_reg.sv
module uclk_ctl_reg #(
  parameter int          DATA_W = 8,
  parameter int          ADDR_W = 8,
  parameter int          CTL_W  = 6,
  parameter logic [7:0]  PORT   = 8'h6D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [DATA_W-1:0] io_rdata
);
  localparam int PAD_W = DATA_W - CTL_W;

  logic hit;
  logic [DATA_W-1:0] rd_word;

  assign hit = (io_addr == PORT[ADDR_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (io_wr && hit) begin
      ctl_q <= io_wdata[CTL_W-1:0];
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_word = {{PAD_W{1'b0}}, ctl_q};
    end else begin : g_nopad
      assign rd_word = ctl_q[DATA_W-1:0];
    end
  endgenerate

  assign io_rdata = (io_rd && hit) ? rd_word : '0;

  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && hit) |=> (ctl_q == $past(io_wdata[CTL_W-1:0]))); // R2
  AST_NO_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && hit) |=> $stable(ctl_q)); // R2
endmodule

// File: rtl/uclk_pre3.sv
module uclk_pre3
  import uclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tri_en,
  input  logic clr,
  output logic pre_tick,
  output logic ph_zero
);
  ph3_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (clr || !tri_en) begin
      ph_d = PH0;
    end else begin
      unique case (ph_q)
        PH0:     ph_d = PH1;
        PH1:     ph_d = PH2;
        default: ph_d = PH0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH0;
    else        ph_q <= ph_d;
  end

  assign pre_tick = !tri_en || (ph_q == PH2);
  assign ph_zero  = (ph_q == PH0);

  AST_PH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q != ph3_e'(2'd3)); // R4
  AST_BYPASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tri_en |=> (ph_q == PH0)); // R4
endmodule

// File: rtl/uclk_bin_chain.sv
module uclk_bin_chain #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [EXP_W-1:0] exp_n,
  output logic             wrap,
  output logic             low_half
);
  localparam int MAX_EXP = (1 << EXP_W) - 1;
  localparam int CNT_W   = (MAX_EXP > 0) ? MAX_EXP : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] limit;
  logic [EXP_W-1:0] half_idx;

  assign span     = ({{CNT_W{1'b0}}, 1'b1} << exp_n);
  assign limit    = span[CNT_W-1:0] - 1'b1;
  assign wrap     = step && (cnt_q == limit);
  assign half_idx = exp_n - 1'b1;
  assign low_half = (exp_n == '0) ? 1'b1 : !cnt_q[half_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit); // R4
  AST_WRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/uclk_div_ctrl.sv
module uclk_div_ctrl
  import uclk_pkg::*;
#(
  parameter int         EXP_W  = 4,
  parameter int         DATA_W = 8,
  parameter int         ADDR_W = 8,
  parameter logic [7:0] PORT   = 8'h6D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              wdog_en,
  output logic              div_clk,
  output logic              div_tick
);
  localparam int TRI_BIT = triple_pos(EXP_W);
  localparam int WD_BIT  = wdog_pos(EXP_W);
  localparam int CTL_W   = WD_BIT + 1;
  localparam int CODE_W  = EXP_W + 1;

  logic [CTL_W-1:0]  ctl_q;
  logic [CODE_W-1:0] act_q;
  logic              act_tri;
  logic [EXP_W-1:0]  act_exp;
  logic              pre_tick, ph_zero, wrap, low_half;
  logic              period_end;

  uclk_ctl_reg #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTL_W(CTL_W), .PORT(PORT)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata),
    .ctl_q(ctl_q), .io_rdata(io_rdata)
  );

  assign act_tri = act_q[TRI_BIT];
  assign act_exp = act_q[EXP_W-1:0];

  uclk_pre3 u_pre3 (
    .clk(clk), .rst_n(rst_n), .tri_en(act_tri), .clr(period_end),
    .pre_tick(pre_tick), .ph_zero(ph_zero)
  );

  uclk_bin_chain #(.EXP_W(EXP_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .step(pre_tick), .exp_n(act_exp),
    .wrap(wrap), .low_half(low_half)
  );

  assign period_end = wrap;

  // active ratio is only reloaded on a period boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          act_q <= '0;
    else if (period_end) act_q <= ctl_q[CODE_W-1:0];
  end

  assign div_tick = period_end;
  assign div_clk  = (act_tri && (act_exp == '0)) ? ph_zero : low_half;
  assign wdog_en  = ctl_q[WD_BIT];

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(act_q)); // R8
  AST_TICK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (div_tick && (act_q != '0)) |-> !div_clk); // R6
  AST_WDOG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && (io_addr == PORT[ADDR_W-1:0])) |=> (wdog_en == $past(io_wdata[WD_BIT]))); // R3
  AST_UNIT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q == '0) |-> (div_tick && div_clk)); // R5
endmodule

// File: tb/uclk_div_ctrl_tb.sv
module uclk_div_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_wr = 1'b0;
  logic       io_rd = 1'b0;
  logic [7:0] io_addr = 8'h00;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic       wdog_en, div_clk, div_tick;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uclk_div_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .wdog_en(wdog_en), .div_clk(div_clk), .div_tick(div_tick)
  );

  // behavioural model: position within period and active ratio
  int m_ctl = 0, m_pos = 0, m_n = 1;

  function automatic int ratio_of(input int c);
    return (((c >> 4) & 1) != 0 ? 3 : 1) << (c & 15);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = 0; m_pos = 0; m_n = 1;
    end else begin
      if (m_pos == m_n - 1) begin
        m_pos = 0;
        m_n = ratio_of(m_ctl & 31);
      end else begin
        m_pos = m_pos + 1;
      end
      if (io_wr && io_addr == 8'h6D) m_ctl = io_wdata & 8'h3F;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  int cyc = 0, last_tick = -1, last_gap = 0;

  always @(negedge clk) begin
    cyc++;
    if (chk_on) begin
      int e_clk;
      int e_rd;
      e_rd  = (io_rd && io_addr == 8'h6D) ? m_ctl : 0;
      e_clk = (m_n == 1) ? 1 : (m_n == 3) ? int'(m_pos == 0) : int'(m_pos < m_n / 2);
      chk("R7 rdata", io_rdata, e_rd);
      chk("R3 wdog_en", wdog_en, (m_ctl >> 5) & 1);
      chk("R5 div_clk", div_clk, e_clk);
      chk("R6 div_tick", div_tick, int'(m_pos == m_n - 1));
    end
    if (rst_n && div_tick) begin
      if (last_tick >= 0) last_gap = cyc - last_tick;
      last_tick = cyc;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(posedge clk); #1;
    io_wr = 1'b0; io_addr = 8'h00;
  endtask

  task automatic rd(output logic [7:0] v);
    @(posedge clk); #1;
    io_rd = 1'b1; io_addr = 8'h6D;
    @(negedge clk);
    v = io_rdata;
    @(posedge clk); #1;
    io_rd = 1'b0; io_addr = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    logic [7:0] v;
    chk_on = 1'b1;
    idle(3);
    // R1: reset state
    chk("R1 wdog_en in reset", wdog_en, 0);
    #1 rst_n = 1'b1;
    rd(v);
    chk("R1 reset readback", v, 8'h00);
    idle(5);
    chk("R1 unit ratio gap", last_gap, 1);
    // R7: upper bits ignored, ratio 12
    wr(8'h6D, 8'hD2);
    rd(v);
    chk("R7 readback masks bits 7:6", v, 8'h12);
    idle(40);
    chk("R4 ratio 12 gap", last_gap, 12);
    // R2: foreign address ignored
    wr(8'h6C, 8'h05);
    rd(v);
    chk("R2 other address ignored", v, 8'h12);
    idle(30);
    chk("R2 ratio unchanged", last_gap, 12);
    // R3: read-modify-write enables watchdog, keeps divider
    rd(v);
    wr(8'h6D, v | 8'h20);
    rd(v);
    chk("R3 rmw readback", v, 8'h32);
    chk("R3 wdog_en set", wdog_en, 1);
    idle(30);
    chk("R3 ratio kept", last_gap, 12);
    // R4: assorted ratios
    wr(8'h6D, 8'h10); idle(20);
    chk("R4 ratio 3 gap", last_gap, 3);
    chk("R3 wdog cleared by plain write", wdog_en, 0);
    wr(8'h6D, 8'h01); idle(10);
    chk("R4 ratio 2 gap", last_gap, 2);
    wr(8'h6D, 8'h00); idle(5);
    chk("R4 ratio 1 gap", last_gap, 1);
    wr(8'h6D, 8'h11); idle(30);
    chk("R4 ratio 6 gap", last_gap, 6);
    wr(8'h6D, 8'h05); idle(80);
    chk("R4 ratio 32 gap", last_gap, 32);
    // R8: mid-period write does not disturb current period
    @(negedge clk);
    while (!div_tick) @(negedge clk);
    idle(10);
    wr(8'h6D, 8'h03);
    idle(15);
    chk("R8 period not cut", last_gap, 32);
    idle(60);
    chk("R8 new ratio 8 gap", last_gap, 8);
    // R9: long ratios
    wr(8'h6D, 8'h0F);
    idle(100);
    wr(8'h6D, 8'h1F);
    idle(32768);
    chk("R9 ratio 32768 gap", last_gap, 32768);
    idle(98600);
    chk("R9 ratio 98304 gap", last_gap, 98304);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 180000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule